// File: doc/BRIEF.md
# Integer/FP Pair Issue Controller

This block sits between instruction fetch and the execution pipelines of an in-order, two-wide core. Each cycle fetch presents a 64-bit packet of two 32-bit instructions. The left half carries an integer-side instruction: an integer ALU operation, a branch, or a load or store, including loads and stores that move floating-point data. The right half carries a floating-point arithmetic operation. The controller decodes both halves and checks the pairing rules. It also checks register dependencies against loads, both within the packet and from the cycle before. It then raises an issue enable for each slot that may go this cycle.

Issue is strictly in order. The right instruction never goes ahead of the left one, and a loaded value cannot be used by the instruction that issues in the same cycle as the load or in the cycle after it. A packet that cannot be fully consumed is held: the controller raises a fetch-hold output and fetch presents the same packet again the next cycle. The controller remembers which half already went out, and it tracks the last issued load itself.

Top module: `dual_pair_issue`

## Requirements
- R1: Instruction fields: opcode in bits [31:26], first source in [25:21], second source (or load destination, or store data) in [20:16]. Default opcodes: FP arithmetic 0x11 (both sources FP), integer reg-reg 0x00, integer load 0x23, FP load 0x31, integer store 0x2B, FP store 0x39, branch 0x04; any other opcode is an integer immediate op reading [25:21]. Load and store bases are integer registers.
- R2: With an integer-side left instruction, an FP arithmetic right instruction and no load dependency, both issue in the same cycle and fetch-hold stays low.
- R3: The right instruction never issues in a cycle in which a valid left instruction of the same packet has neither issued earlier nor issues.
- R4: If the left instruction is an FP arithmetic op, or the right one is not, only the left issues first; the packet is held and the right issues alone on a later cycle; the left is not issued twice.
- R5: A right instruction that reads the destination of the load in its own left slot, in the same register file, does not issue in that cycle nor in the next one; it issues on the third cycle (one stall cycle).
- R6: An instruction that reads the destination of a load issued in the previous cycle does not issue in this cycle. If it is the left instruction, neither instruction issues and stall is high.
- R7: An FP load in the left slot paired with an FP operation that does not read its destination issues together with it in one cycle.
- R8: Integer and FP registers are separate: an integer load never blocks a reader of the FP register with the same number, and an integer load to register 0 blocks nobody.
- R9: A load blocks readers for exactly one cycle beyond its own: after one stall cycle the blocked instruction issues.
- R10: An invalid slot never issues; with the left slot empty, a valid right instruction may issue alone.
- R11: Fetch-hold is high exactly when a valid instruction of the current packet is still pending after this cycle; stall is high when fetch-hold is high and nothing issues.
- R12: While reset is high nothing issues and fetch-hold is low; after reset no earlier load blocks any instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| left_insn | input | 32 | Left (integer-side) instruction of the packet |
| left_vld | input | 1 | Left instruction present |
| right_insn | input | 32 | Right (FP arithmetic) instruction of the packet |
| right_vld | input | 1 | Right instruction present |
| issue_left | output | 1 | Left instruction issues this cycle |
| issue_right | output | 1 | Right instruction issues this cycle |
| stall | output | 1 | Packet pending and nothing issues this cycle |
| fetch_hold | output | 1 | Re-present the same packet next cycle |

## Verification
The bench builds the controller with its default opcode values and 5-bit register specifiers, so all 64 left/right opcode-class combinations can be swept. It also sweeps every one of the 32 FP load destinations against several FP operand numbers, and every integer load destination against the FP operand of the same number. With this small configuration the expected issue cycle of each half and the number of stall cycles follow from simple arithmetic on the register numbers. Directed back-to-back packets then cover the previous-cycle load window, register 0, an empty left slot and a missing right instruction.

// File: rtl/pairiss_pkg.sv
package pairiss_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - REG_W;
    localparam int RB_LSB  = RA_LSB - REG_W;
    localparam int NSLOT   = 2;

    typedef enum logic [2:0] {
        K_FPOP,
        K_RREG,
        K_LDINT,
        K_LDFP,
        K_STINT,
        K_STFP,
        K_BRANCH,
        K_IMM
    } insn_kind_e;

    // One register reference: present, register file (1 = FP), number.
    typedef struct packed {
        logic             vld;
        logic             fp;
        logic [REG_W-1:0] num;
    } reg_ref_t;

    typedef struct packed {
        insn_kind_e kind;
        reg_ref_t   src_a;
        reg_ref_t   src_b;
        reg_ref_t   ld_dst;
    } slot_dec_t;

    function automatic logic ref_match(reg_ref_t rd, reg_ref_t wr);
        return rd.vld && wr.vld && (rd.fp == wr.fp) && (rd.num == wr.num);
    endfunction

    function automatic logic reads_ref(slot_dec_t d, reg_ref_t wr);
        return ref_match(d.src_a, wr) || ref_match(d.src_b, wr);
    endfunction

endpackage

// File: rtl/pair_slot_decode.sv
module pair_slot_decode
    import pairiss_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_FPOP   = 6'h11,
    parameter logic [OPC_W-1:0] OP_RREG   = 6'h00,
    parameter logic [OPC_W-1:0] OP_LDINT  = 6'h23,
    parameter logic [OPC_W-1:0] OP_LDFP   = 6'h31,
    parameter logic [OPC_W-1:0] OP_STINT  = 6'h2B,
    parameter logic [OPC_W-1:0] OP_STFP   = 6'h39,
    parameter logic [OPC_W-1:0] OP_BRANCH = 6'h04
) (
    input  logic [INSN_W-1:0] insn,
    input  logic              vld,
    output slot_dec_t         dec
);

    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] fa;
    logic [REG_W-1:0] fb;
    logic             unused_low;

    assign opc        = insn[OPC_LSB +: OPC_W];
    assign fa         = insn[RA_LSB +: REG_W];
    assign fb         = insn[RB_LSB +: REG_W];
    assign unused_low = ^insn[RB_LSB-1:0];

    always_comb begin
        dec        = '0;
        dec.kind   = K_IMM;
        dec.src_a  = '{1'b1, 1'b0, fa};
        dec.src_b  = '0;
        dec.ld_dst = '0;
        if (opc == OP_FPOP) begin
            dec.kind  = K_FPOP;
            dec.src_a = '{1'b1, 1'b1, fa};
            dec.src_b = '{1'b1, 1'b1, fb};
        end else if (opc == OP_RREG) begin
            dec.kind  = K_RREG;
            dec.src_b = '{1'b1, 1'b0, fb};
        end else if (opc == OP_LDINT) begin
            dec.kind   = K_LDINT;
            dec.ld_dst = '{(fb != '0), 1'b0, fb};
        end else if (opc == OP_LDFP) begin
            dec.kind   = K_LDFP;
            dec.ld_dst = '{1'b1, 1'b1, fb};
        end else if (opc == OP_STINT) begin
            dec.kind  = K_STINT;
            dec.src_b = '{1'b1, 1'b0, fb};
        end else if (opc == OP_STFP) begin
            dec.kind  = K_STFP;
            dec.src_b = '{1'b1, 1'b1, fb};
        end else if (opc == OP_BRANCH) begin
            dec.kind = K_BRANCH;
        end
        if (!vld) begin
            dec.src_a.vld  = 1'b0;
            dec.src_b.vld  = 1'b0;
            dec.ld_dst.vld = 1'b0;
        end
    end

    always_comb begin
        if (vld && dec.ld_dst.vld && !dec.ld_dst.fp) begin
            AST_NO_R0_LOAD_TAG: assert (dec.ld_dst.num != '0); // R8
        end
    end

endmodule

// File: rtl/pair_hazard_chk.sv
module pair_hazard_chk
    import pairiss_pkg::*;
(
    input  slot_dec_t reader,
    input  reg_ref_t  writer,
    output logic      hit
);

    assign hit = reads_ref(reader, writer);

endmodule

// File: rtl/pair_issue_ctrl.sv
module pair_issue_ctrl
    import pairiss_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      l_vld,
    input  logic      r_vld,
    input  slot_dec_t l_dec,
    input  slot_dec_t r_dec,
    input  logic      l_haz_prev,
    input  logic      r_haz_prev,
    input  logic      r_haz_pair,
    output reg_ref_t  ld_q,
    output logic      issue_l,
    output logic      issue_r,
    output logic      hold,
    output logic      stall
);

    logic split_q;
    logic lv;
    logic rv;
    logic l_pend;
    logic pair_ok;
    logic r_front;

    always_comb begin
        lv      = l_vld && !rst;
        rv      = r_vld && !rst;
        l_pend  = lv && !split_q;
        issue_l = l_pend && !l_haz_prev;
        pair_ok = (l_dec.kind != K_FPOP) && (r_dec.kind == K_FPOP);
        r_front = split_q || !lv || (issue_l && pair_ok);
        issue_r = rv && r_front && !r_haz_prev && !(issue_l && r_haz_pair);
        hold    = (l_pend && !issue_l) || (rv && !issue_r);
        stall   = hold && !issue_l && !issue_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            split_q <= 1'b0;
            ld_q    <= '0;
        end else begin
            split_q <= hold && lv && (split_q || issue_l);
            if (issue_r && r_dec.ld_dst.vld) begin
                ld_q <= r_dec.ld_dst;
            end else if (issue_l) begin
                ld_q <= l_dec.ld_dst;
            end else begin
                ld_q <= '0;
            end
        end
    end

    AST_RIGHT_AFTER_LEFT: assert property (@(posedge clk) disable iff (rst)
        (issue_r && l_vld && !split_q) |-> issue_l); // R3

    AST_LEFT_SLOT_VALID: assert property (@(posedge clk) disable iff (rst)
        issue_l |-> l_vld); // R10

    AST_RIGHT_SLOT_VALID: assert property (@(posedge clk) disable iff (rst)
        issue_r |-> r_vld); // R10

    AST_PAIR_KINDS: assert property (@(posedge clk) disable iff (rst)
        (issue_l && issue_r) |-> (l_dec.kind != K_FPOP && r_dec.kind == K_FPOP)); // R4

    AST_NO_LEFT_REISSUE: assert property (@(posedge clk) disable iff (rst)
        (issue_l && hold) |=> !issue_l); // R4

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
        (r_vld && !issue_r) |-> hold); // R11

    AST_SAME_PACKET_LOAD: assert property (@(posedge clk) disable iff (rst)
        (issue_l && issue_r && l_dec.ld_dst.vld) |-> !reads_ref(r_dec, l_dec.ld_dst)); // R5

    AST_LOAD_DELAY_LEFT: assert property (@(posedge clk) disable iff (rst)
        (issue_l && $past(issue_l) && $past(l_dec.ld_dst.vld))
            |-> !reads_ref(l_dec, $past(l_dec.ld_dst))); // R6

    AST_LOAD_DELAY_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (issue_r && $past(issue_l) && $past(l_dec.ld_dst.vld))
            |-> !reads_ref(r_dec, $past(l_dec.ld_dst))); // R6

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!issue_l && !issue_r && !hold)); // R12

endmodule

// File: rtl/dual_pair_issue.sv
module dual_pair_issue
    import pairiss_pkg::*;
#(
    parameter logic [OPC_W-1:0] OP_FPOP   = 6'h11,
    parameter logic [OPC_W-1:0] OP_RREG   = 6'h00,
    parameter logic [OPC_W-1:0] OP_LDINT  = 6'h23,
    parameter logic [OPC_W-1:0] OP_LDFP   = 6'h31,
    parameter logic [OPC_W-1:0] OP_STINT  = 6'h2B,
    parameter logic [OPC_W-1:0] OP_STFP   = 6'h39,
    parameter logic [OPC_W-1:0] OP_BRANCH = 6'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INSN_W-1:0] left_insn,
    input  logic              left_vld,
    input  logic [INSN_W-1:0] right_insn,
    input  logic              right_vld,
    output logic              issue_left,
    output logic              issue_right,
    output logic              stall,
    output logic              fetch_hold
);

    logic [INSN_W-1:0] slot_insn [NSLOT];
    logic              slot_vld  [NSLOT];
    slot_dec_t         slot_dec  [NSLOT];
    reg_ref_t          ld_q;
    logic              l_haz_prev;
    logic              r_haz_prev;
    logic              r_haz_pair;

    assign slot_insn[0] = left_insn;
    assign slot_insn[1] = right_insn;
    assign slot_vld[0]  = left_vld;
    assign slot_vld[1]  = right_vld;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        pair_slot_decode #(
            .OP_FPOP  (OP_FPOP),
            .OP_RREG  (OP_RREG),
            .OP_LDINT (OP_LDINT),
            .OP_LDFP  (OP_LDFP),
            .OP_STINT (OP_STINT),
            .OP_STFP  (OP_STFP),
            .OP_BRANCH(OP_BRANCH)
        ) i_dec (
            .insn(slot_insn[s]),
            .vld (slot_vld[s]),
            .dec (slot_dec[s])
        );
    end

    pair_hazard_chk i_haz_l_prev (
        .reader(slot_dec[0]),
        .writer(ld_q),
        .hit   (l_haz_prev)
    );

    pair_hazard_chk i_haz_r_prev (
        .reader(slot_dec[1]),
        .writer(ld_q),
        .hit   (r_haz_prev)
    );

    pair_hazard_chk i_haz_r_pair (
        .reader(slot_dec[1]),
        .writer(slot_dec[0].ld_dst),
        .hit   (r_haz_pair)
    );

    pair_issue_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .l_vld     (left_vld),
        .r_vld     (right_vld),
        .l_dec     (slot_dec[0]),
        .r_dec     (slot_dec[1]),
        .l_haz_prev(l_haz_prev),
        .r_haz_prev(r_haz_prev),
        .r_haz_pair(r_haz_pair),
        .ld_q      (ld_q),
        .issue_l   (issue_left),
        .issue_r   (issue_right),
        .hold      (fetch_hold),
        .stall     (stall)
    );

    AST_STALL_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |-> (fetch_hold && !issue_left && !issue_right)); // R11

endmodule

// File: tb/test_dual_pair_issue.sv
module test_dual_pair_issue;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] O_FP  = 6'h11;
    localparam logic [5:0] O_RR  = 6'h00;
    localparam logic [5:0] O_LDI = 6'h23;
    localparam logic [5:0] O_LDF = 6'h31;
    localparam logic [5:0] O_STI = 6'h2B;
    localparam logic [5:0] O_STF = 6'h39;
    localparam logic [5:0] O_BR  = 6'h04;
    localparam logic [5:0] O_IMM = 6'h08;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] left_insn = '0;
    logic        left_vld = 1'b0;
    logic [31:0] right_insn = '0;
    logic        right_vld = 1'b0;
    logic        issue_left;
    logic        issue_right;
    logic        stall;
    logic        fetch_hold;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pair_issue i_dual_pair_issue (
        .clk        (clk),
        .rst        (rst),
        .left_insn  (left_insn),
        .left_vld   (left_vld),
        .right_insn (right_insn),
        .right_vld  (right_vld),
        .issue_left (issue_left),
        .issue_right(issue_right),
        .stall      (stall),
        .fetch_hold (fetch_hold)
    );

    function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] a, logic [4:0] b);
        return {op, a, b, 5'd9, 11'd0};
    endfunction

    function automatic logic [5:0] kind_op(int k);
        case (k)
            0: return O_FP;
            1: return O_RR;
            2: return O_LDI;
            3: return O_LDF;
            4: return O_STI;
            5: return O_STF;
            6: return O_BR;
            default: return O_IMM;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present a packet and follow it until fetch_hold drops.
    // cl/cr: cycle index in which each half issued (-1: never); ns: stall cycles.
    task automatic send(input logic [31:0] li, input logic lv, input logic [31:0] ri,
                        input logic rv, output int cl, output int cr, output int ns);
        cl = -1; cr = -1; ns = 0;
        @(negedge clk);
        left_insn = li; left_vld = lv; right_insn = ri; right_vld = rv;
        for (int k = 0; k < 8; k++) begin
            #1;
            if (issue_left) cl = k;
            if (issue_right) cr = k;
            if (stall) ns++;
            if (!fetch_hold) break;
            @(negedge clk);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        left_vld = 1'b0; right_vld = 1'b0;
    endtask

    task automatic expect3(input string req, input int cl, input int cr, input int ns,
                           input int el, input int er, input int es);
        chk(req, cl, el, "left issue cycle");
        chk(req, cr, er, "right issue cycle");
        chk(req, ns, es, "stall cycles");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cl, cr, ns;
        // R12: outputs quiet while reset is high, even with valid packet
        #2;
        left_insn = mk(O_RR, 1, 2); left_vld = 1'b1;
        right_insn = mk(O_FP, 3, 4); right_vld = 1'b1;
        #1;
        chk("R12", int'(issue_left), 0, "issue_left in reset");
        chk("R12", int'(issue_right), 0, "issue_right in reset");
        chk("R12", int'(fetch_hold), 0, "fetch_hold in reset");
        repeat (3) @(negedge clk);
        rst = 1'b0;
        left_vld = 1'b0; right_vld = 1'b0;
        #1;
        chk("R12", int'(fetch_hold), 0, "fetch_hold idle after reset");

        // R12: first packet after reset is not blocked
        send(mk(O_RR, 0, 2), 1'b1, mk(O_FP, 0, 2), 1'b1, cl, cr, ns);
        expect3("R12", cl, cr, ns, 0, 0, 0);
        idle();

        // R2 R4 R1: sweep of all opcode classes in both slots
        for (int lk = 0; lk < 8; lk++) begin
            for (int rk = 0; rk < 8; rk++) begin
                bit pair;
                pair = (lk != 0) && (rk == 0);
                send(mk(kind_op(lk), 1, 2), 1'b1, mk(kind_op(rk), 4, 5), 1'b1, cl, cr, ns);
                expect3(pair ? "R2" : "R4", cl, cr, ns, 0, pair ? 0 : 1, 0);
                idle();
            end
        end

        // R5 R7 R9: FP load destination vs FP operand in the same packet
        for (int d = 0; d < 32; d++) begin
            for (int j = 0; j < 4; j++) begin
                int s;
                s = (j == 0) ? 0 : (j == 1) ? 5 : (j == 2) ? 17 : 31;
                send(mk(O_LDF, 1, d[4:0]), 1'b1, mk(O_FP, s[4:0], s[4:0]), 1'b1, cl, cr, ns);
                if (d == s) expect3("R5", cl, cr, ns, 0, 2, 1);
                else        expect3("R7", cl, cr, ns, 0, 0, 0);
                idle();
            end
        end

        // R8: integer load never blocks the FP register of the same number
        for (int d = 1; d < 32; d++) begin
            send(mk(O_LDI, 1, d[4:0]), 1'b1, mk(O_FP, d[4:0], d[4:0]), 1'b1, cl, cr, ns);
            expect3("R8", cl, cr, ns, 0, 0, 0);
            idle();
        end

        // R8: integer load to register 0, next packet reads register 0
        send(mk(O_LDI, 1, 0), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        send(mk(O_RR, 0, 0), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        expect3("R8", cl, cr, ns, 0, 0, 0);
        idle();

        // R6 R9 R3: next packet's left reads previous load; whole packet waits
        send(mk(O_LDI, 1, 6), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        expect3("R7", cl, cr, ns, 0, 0, 0);
        send(mk(O_RR, 6, 2), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        expect3("R6", cl, cr, ns, 1, 1, 1);
        chk("R3", int'(cr >= cl), 1, "right not before left");
        idle();

        // R6: next packet's right reads previous FP load; left goes alone
        send(mk(O_LDF, 1, 12), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        send(mk(O_RR, 1, 2), 1'b1, mk(O_FP, 12, 3), 1'b1, cl, cr, ns);
        expect3("R6", cl, cr, ns, 0, 1, 0);
        idle();

        // R6 R9: FP store data reads previous FP load
        send(mk(O_LDF, 1, 13), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        send(mk(O_STF, 1, 13), 1'b1, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        expect3("R9", cl, cr, ns, 1, 1, 1);
        idle();

        // R10: empty left slot lets the right instruction go alone
        send(mk(O_RR, 1, 2), 1'b0, mk(O_FP, 7, 8), 1'b1, cl, cr, ns);
        expect3("R10", cl, cr, ns, -1, 0, 0);
        idle();

        // R10 R11: missing right instruction, left alone, no hold
        send(mk(O_RR, 1, 2), 1'b1, mk(O_FP, 7, 8), 1'b0, cl, cr, ns);
        expect3("R10", cl, cr, ns, 0, -1, 0);
        chk("R11", int'(fetch_hold), 0, "fetch_hold after lone left");
        idle();

        // R11: split packet holds fetch in its first cycle
        @(negedge clk);
        left_insn = mk(O_FP, 1, 2); left_vld = 1'b1;
        right_insn = mk(O_FP, 3, 4); right_vld = 1'b1;
        #1;
        chk("R11", int'(fetch_hold), 1, "fetch_hold on split");
        chk("R11", int'(stall), 0, "stall on split with left issuing");
        @(negedge clk);
        #1;
        chk("R4", int'(issue_left), 0, "left not reissued");
        chk("R4", int'(issue_right), 1, "right issues alone");
        idle();
        #1;

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule